// File: doc/BRIEF.md
# Quadrature Sine/Cosine Quarter-Table Converter

This block turns a truncated phase word into a pair of signed quadrature samples (sine and cosine) and a two-level square wave. It sits after a phase accumulator. The upper bits of the accumulator drive the phase input, and a valid strobe marks the cycles that carry a new phase. The outputs go to a mixer, a modulator or a converter downstream.

Only one quarter of a sine period is held in a computed table. The two top phase bits name the quadrant. One of them decides whether the table is read forward or mirrored, and the other decides whether the result is negated. The cosine channel reuses the same folding after advancing the quadrant field by one. Each table entry is sampled at the centre of its phase step. Because of this, a mirrored read lands exactly on the symmetric sample. The outputs carry a fixed two-clock latency, and a matching valid flag travels with them.

Top module: `quad_sine_lut`

## Requirements
- R1: While reset is high, and after it is released, sin_out, cos_out, sq_out and out_valid are all zero until the first valid phase reaches the outputs.
- R2: For phase code p (PHASE_W = 13 bits, AMP_W = 12 bits), sin_out equals round(2048·sin(2π(p+0.5)/8192)) clipped to ±2047, within ±1 LSB.
- R3: For the same code, cos_out equals round(2048·cos(2π(p+0.5)/8192)) clipped to ±2047, within ±1 LSB.
- R4: Neither sample ever takes the value −2048, so every magnitude is at most 2047.
- R5: A phase presented with in_valid high before clock edge n produces out_valid high, together with its samples, after edge n+1. out_valid is in_valid delayed by exactly two clocks.
- R6: sq_out is +1 (2'b01) when phase bit 12 (the MSB) is 0, and −1 (2'b11) when it is 1.
- R7: A cycle with in_valid low loads nothing: two clocks later out_valid is low, and sin_out, cos_out and sq_out keep their previous values.
- R8: The sine sample at code p + 4096 (mod 8192) is the exact negation of the sine sample at code p.
- R9: The cosine sample at code p is exactly equal to the sine sample at code p + 2048 (mod 8192).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a cycle carrying a new phase |
| phase_in | input | PHASE_W (13) | Phase word; the top two bits are the quadrant |
| sin_out | output | AMP_W (12) | Signed sine sample |
| cos_out | output | AMP_W (12) | Signed cosine sample |
| sq_out | output | 2 | Signed square wave, +1 or −1 |
| out_valid | output | 1 | Samples on the outputs are new this cycle |

## Verification
The assertions assume that reset is held for at least one rising edge, so that every pipeline register starts at zero. The valid-delay property only starts checking two edges after reset, once both delay stages hold post-reset values. The assertions assume nothing about the phase value itself. The stimulus therefore sweeps every phase code back to back with the strobe held high, then mixes random phases with random strobe gaps and a few hand-picked quadrant edges. This exercises the hold behaviour and every mirror and negate combination.

// File: rtl/qs_pkg.sv
package qs_pkg;

    // Quadrant advance that turns the sine fold into a cosine fold.
    localparam logic [1:0] QUARTER_STEP = 2'b01;

    typedef enum logic {
        CH_SIN = 1'b0,
        CH_COS = 1'b1
    } chan_e;

    // Folding controls decoded from the two quadrant bits.
    typedef struct packed {
        logic mirror;   // read the quarter table backwards
        logic flip;     // negate the table magnitude
    } fold_ctl_t;

    function automatic fold_ctl_t decode_quadrant(input logic [1:0] quad);
        fold_ctl_t f;
        f.mirror = quad[0];
        f.flip   = quad[1];
        return f;
    endfunction

    // Encoding of the square-wave output.
    localparam logic signed [1:0] SQ_POS = 2'sb01;
    localparam logic signed [1:0] SQ_NEG = 2'sb11;

endpackage

// File: rtl/qs_quarter_rom.sv
module qs_quarter_rom #(
    parameter int IDX_W = 11,
    parameter int MAG_W = 11
) (
    input  logic [IDX_W-1:0] idx,
    output logic [MAG_W-1:0] mag
);
    localparam int  DEPTH = 1 << IDX_W;
    localparam real FULL  = real'(1 << MAG_W);
    localparam int  TOP   = (1 << MAG_W) - 1;
    localparam real HALF_PI = 1.5707963267948966;

    logic [MAG_W-1:0] tbl [DEPTH];

    // Each entry is taken at the centre of its phase step, so mirrored
    // addresses hit exactly symmetric samples.
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam real ANG = (real'(k) + 0.5) * HALF_PI / real'(DEPTH);
        localparam int  RAW = int'(FULL * $sin(ANG));
        localparam int  VAL = (RAW > TOP) ? TOP : RAW;
        assign tbl[k] = MAG_W'(VAL);
    end

    assign mag = tbl[idx];
endmodule

// File: rtl/qs_channel.sv
module qs_channel #(
    parameter int PHASE_W = 13,
    parameter int AMP_W   = 12,
    parameter bit COS_CH  = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_fold,
    input  logic                    ld_samp,
    input  logic [PHASE_W-1:0]      phase,
    output logic signed [AMP_W-1:0] samp
);
    import qs_pkg::*;

    localparam int IDX_W = PHASE_W - 2;
    localparam int MAG_W = AMP_W - 1;

    logic [1:0]       quad;
    logic [IDX_W-1:0] low_bits;
    logic [IDX_W-1:0] idx_c;
    fold_ctl_t        ctl;

    logic [IDX_W-1:0] idx_q;
    logic             flip_q;
    logic [MAG_W-1:0] mag;
    logic signed [AMP_W-1:0] pos_s;
    logic signed [AMP_W-1:0] samp_d;

    // Stage 1: quadrant advance (cosine only), then reflect the address.
    assign quad     = phase[PHASE_W-1 -: 2] + (COS_CH ? QUARTER_STEP : 2'b00);
    assign low_bits = phase[IDX_W-1:0];

    always_comb begin
        ctl   = decode_quadrant(quad);
        idx_c = ctl.mirror ? ~low_bits : low_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            flip_q <= 1'b0;
        end else if (ld_fold) begin
            idx_q  <= idx_c;
            flip_q <= ctl.flip;
        end
    end

    qs_quarter_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) rom_i (
        .idx (idx_q),
        .mag (mag)
    );

    // Stage 2: restore the sign.
    always_comb begin
        pos_s  = signed'({1'b0, mag});
        samp_d = flip_q ? -pos_s : pos_s;
    end

    always_ff @(posedge clk) begin
        if (rst)          samp <= '0;
        else if (ld_samp) samp <= samp_d;
    end
endmodule

// File: rtl/quad_sine_lut.sv
module quad_sine_lut #(
    parameter int PHASE_W = 13,
    parameter int AMP_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [PHASE_W-1:0]      phase_in,
    output logic signed [AMP_W-1:0] sin_out,
    output logic signed [AMP_W-1:0] cos_out,
    output logic signed [1:0]       sq_out,
    output logic                    out_valid
);
    import qs_pkg::*;

    localparam int NCH = 2;

    logic                    v1;
    logic                    msb_q;
    logic signed [AMP_W-1:0] samp [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            out_valid <= v1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        qs_channel #(
            .PHASE_W (PHASE_W),
            .AMP_W   (AMP_W),
            .COS_CH  (c == int'(CH_COS))
        ) ch_i (
            .clk     (clk),
            .rst     (rst),
            .ld_fold (in_valid),
            .ld_samp (v1),
            .phase   (phase_in),
            .samp    (samp[c])
        );
    end

    assign sin_out = samp[int'(CH_SIN)];
    assign cos_out = samp[int'(CH_COS)];

    // Square wave: sign of the sine, taken from the phase MSB.
    always_ff @(posedge clk) begin
        if (rst) begin
            msb_q  <= 1'b0;
            sq_out <= '0;
        end else begin
            if (in_valid) msb_q  <= phase_in[PHASE_W-1];
            if (v1)       sq_out <= msb_q ? SQ_NEG : SQ_POS;
        end
    end
endmodule

// File: rtl/qs_chk.sv
module qs_chk #(
    parameter int PHASE_W = 13,
    parameter int AMP_W   = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic signed [AMP_W-1:0] sin_out,
    input logic signed [AMP_W-1:0] cos_out,
    input logic signed [1:0]       sq_out,
    input logic                    out_valid
);
    localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_range_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sin_out != MOST_NEG && cos_out != MOST_NEG));

    p_sq_levels_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sq_out == 2'sb01 || sq_out == 2'sb11));

    p_sq_pos_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sq_out == 2'sb01) |-> (sin_out >= 0));

    p_sq_neg_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sq_out == 2'sb11) |-> (sin_out <= 0));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(sin_out) && $stable(cos_out) && $stable(sq_out)));
endmodule

bind quad_sine_lut qs_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) chk_i (.*);

// File: tb/quad_sine_lut_tb_top.sv
module quad_sine_lut_tb_top;
    localparam int PW  = 13;
    localparam int AW  = 12;
    localparam int NP  = 1 << PW;
    localparam real TWO_PI = 6.283185307179586;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [PW-1:0]        phase_in = '0;
    logic signed [AW-1:0] sin_out, cos_out;
    logic signed [1:0]    sq_out;
    logic                 out_valid;

    always #10 clk = ~clk;

    quad_sine_lut #(.PHASE_W(PW), .AMP_W(AW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .phase_in(phase_in),
        .sin_out(sin_out), .cos_out(cos_out), .sq_out(sq_out),
        .out_valid(out_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    bit h_v [2];
    int h_p [2];
    int exp_s = 0, exp_c = 0, exp_q = 0;
    int rec_s [NP];
    int rec_c [NP];

    function automatic int ref_wave(int p, bit want_cos);
        real a, v;
        int  r;
        a = TWO_PI * (real'(p) + 0.5) / real'(NP);
        v = 2048.0 * (want_cos ? $cos(a) : $sin(a));
        r = int'(v);
        if (r > 2047)  r = 2047;
        if (r < -2047) r = -2047;
        return r;
    endfunction

    task automatic check_eq(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_near(string req, int act, int expv);
        n_chk++;
        if (act > expv + 1 || act < expv - 1) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (+-1)", req, act, expv);
        end
    endtask

    // One cycle: check outputs for the phase driven two negedges ago,
    // then drive the next input.
    task automatic step(bit v, int p);
        @(negedge clk);
        check_eq("R5 out_valid", int'(out_valid), int'(h_v[1]));
        if (h_v[1]) begin
            exp_s = ref_wave(h_p[1], 1'b0);
            exp_c = ref_wave(h_p[1], 1'b1);
            exp_q = (h_p[1] >= NP/2) ? -1 : 1;
            rec_s[h_p[1]] = int'(sin_out);
            rec_c[h_p[1]] = int'(cos_out);
            check_near("R2 sine", int'(sin_out), exp_s);
            check_near("R3 cosine", int'(cos_out), exp_c);
            check_eq("R6 square", int'(sq_out), exp_q);
            n_chk++;
            if (sin_out == -2048 || cos_out == -2048) begin
                n_bad++;
                $display("FAIL R4 actual=%0d/%0d expected=not -2048", sin_out, cos_out);
            end
        end else begin
            check_near("R7 hold sine", int'(sin_out), exp_s);
            check_near("R7 hold cosine", int'(cos_out), exp_c);
            check_eq("R7 hold square", int'(sq_out), exp_q);
        end
        h_v[1] = h_v[0]; h_p[1] = h_p[0];
        h_v[0] = v;      h_p[0] = p;
        in_valid = v;
        phase_in = PW'(p);
    endtask

    initial begin
        int seed;
        h_v[0] = 0; h_v[1] = 0; h_p[0] = 0; h_p[1] = 0;
        for (int i = 0; i < NP; i++) begin rec_s[i] = 9999; rec_c[i] = 9999; end
        seed = $urandom(32'h5EED_0013);
        // R1: reset state, with stimulus active
        in_valid = 1'b1; phase_in = PW'(1000);
        repeat (3) @(negedge clk);
        check_eq("R1 sin reset", int'(sin_out), 0);
        check_eq("R1 cos reset", int'(cos_out), 0);
        check_eq("R1 sq reset", int'(sq_out), 0);
        check_eq("R1 valid reset", int'(out_valid), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 valid after release", int'(out_valid), 0);
        check_eq("R1 sin after release", int'(sin_out), 0);

        // Directed quadrant edges
        step(1, 0); step(1, 2047); step(1, 2048); step(1, 4095);
        step(1, 4096); step(1, 6143); step(1, 6144); step(1, NP-1);
        step(0, 17); step(0, 5000);
        // Full sweep
        for (int p = 0; p < NP; p++) step(1, p);
        step(0, 0); step(0, 0);
        // R8 / R9 exact symmetry from recorded sweep
        for (int p = 0; p < NP; p++) begin
            check_eq("R8 half-period negation", rec_s[(p + NP/2) % NP], -rec_s[p]);
            check_eq("R9 cosine is shifted sine", rec_c[p], rec_s[(p + NP/4) % NP]);
        end
        // Random with strobe gaps (R7)
        for (int i = 0; i < 4000; i++) begin
            bit v;
            v = ($urandom % 4) != 0;
            step(v, int'($urandom % NP));
        end
        step(0, 0); step(0, 0); step(0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule